// File: doc/BRIEF.md
# Two-Thread Switch-on-Event Controller

This block chooses which of two hardware threads owns the front end of a processor that runs one thread at a time. It holds a program counter for each thread. It drives the fetch stage with the active thread's PC and with a register-file bank select, which is the same as the active thread number. It moves the processor to the other thread only when the running thread reports a long-latency event, such as a data-cache miss or a translation miss. It also moves when a programmable run-length limit runs out, so that the waiting thread is never starved. A switch happens only if the other thread has reported that it is ready.

On a switch, the controller raises a flush request for one cycle. In the same clock edge it stores the restart address given with the miss into the outgoing thread's PC slot. From the next cycle it presents the incoming thread's stored PC. The pipeline drives a per-thread PC update port to advance or redirect either thread. Software sets the run-length limit through a single configuration write port. A limit of zero turns the forced switch off.

Top module: `thread_switch_ctrl`

## Requirements
- R1: After a synchronous active-low reset, thread 0 is active. The bank select is 0 and `flush_req` is 0. `switch_cause` is 2'b00. Both thread PCs hold the value of `reset_vec` sampled during reset, so `active_pc` equals `reset_vec`.
- R2: A long event is `stall_evt` = 2'b10 (data miss) or 2'b11 (translation miss). If a long event occurs while the other thread's ready bit is 1, the following cycle has all of these: `active_tid` and `rf_bank_sel` switched to the other thread, `flush_req` high for exactly that one cycle, and `active_pc` equal to the other thread's stored PC.
- R3: On a switch caused by a long event, `restart_pc` is stored as the outgoing thread's PC. It is presented when that thread becomes active again.
- R4: `stall_evt` = 2'b00 (none) and 2'b01 (short stall) never cause a switch.
- R5: A long event while the other thread's ready bit is 0 causes no switch. The current thread stays active and no flush is raised.
- R6: With a nonzero limit N, a thread that sees no long event is switched out after exactly N cycles as the active thread, and the cause is 2'b10. If the other thread is not ready at that point, the timeout stays pending and the switch happens on the first cycle in which the other thread's ready bit is 1.
- R7: A limit of 0 disables the forced switch.
- R8: The run-length count restarts from zero on every switch, so each newly active thread gets a full N cycles.
- R9: If a long event and a timeout fall in the same cycle, only one switch is made and `switch_cause` reads 2'b01 (miss).
- R10: `pc_upd_en[i]` loads the matching `pc_upd_t0` or `pc_upd_t1` value into thread i's PC. An update to the inactive thread does not change `active_pc`.
- R11: `cfg_we` loads `cfg_limit` as the run-length limit, taking effect from the next cycle. The limit is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_vec | input | PC_W | Start address loaded into both thread PCs during reset |
| stall_evt | input | 2 | Stall code of the active thread: 00 none, 01 short, 10 data miss, 11 translation miss |
| restart_pc | input | PC_W | Address at which the stalled thread resumes |
| thr_ready | input | 2 | Per-thread ready bit; bit i set when thread i may run |
| pc_upd_en | input | 2 | Per-thread PC write enable |
| pc_upd_t0 | input | PC_W | New PC for thread 0 |
| pc_upd_t1 | input | PC_W | New PC for thread 1 |
| cfg_we | input | 1 | Write strobe for the run-length limit |
| cfg_limit | input | CNT_W | New run-length limit in cycles; 0 disables |
| active_tid | output | 1 | Number of the running thread |
| rf_bank_sel | output | 1 | Register-file copy selected for the running thread |
| active_pc | output | PC_W | Stored PC of the running thread |
| flush_req | output | 1 | One-cycle pipeline flush/drain request after a switch |
| switch_cause | output | 2 | Cause of the latest switch: 00 none yet, 01 miss, 10 limit |

## Verification
The hardest case to reach from the ports is a miss that lands in exactly the cycle in which the run-length limit expires. The count is internal, so the bench times it from a flush pulse it observes. With a limit of four, the cycle of the flush is count zero. The bench advances three more cycles and then presents the miss. It checks that the miss gives a single switch reported as a miss and that the new thread still receives its full four cycles. A pending timeout held back by a thread that is not ready is reached the same way. The bench then raises the ready bit late and expects the switch on the very next edge.

// File: rtl/tsc_pkg.sv
// Shared definitions for the two-thread switch controller.
// Assumes exactly two hardware threads, so a thread number is one bit wide.
package tsc_pkg;
    localparam int NUM_THR = 2;
    localparam int TID_W   = 1;

    // Stall event codes reported by the pipeline for the active thread
    typedef enum logic [1:0] {
        EVT_NONE  = 2'b00,
        EVT_SHORT = 2'b01,
        EVT_DMISS = 2'b10,
        EVT_TMISS = 2'b11
    } stall_evt_e;

    // Reason recorded for the latest thread switch
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_MISS  = 2'b01,
        CAUSE_LIMIT = 2'b10
    } sw_cause_e;
endpackage

// File: rtl/tsc_run_timer.sv
// Run-length timer: counts the cycles the active thread has held the
// processor since the last switch and flags when the programmed limit is
// reached. A limit of zero never flags. The count freezes while a timeout
// is pending, so the flag stays high until the switch is taken.
// Assumes sw_take is a single-cycle pulse at the switching edge.
module tsc_run_timer #(
    parameter int CNT_W     = 16,
    parameter int RST_LIMIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             sw_take,
    output logic             limit_hit,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] limit_q
);
    localparam int CW1 = CNT_W + 1;

    logic [CW1-1:0] cnt_next_ext;

    // Widened next-count so the compare cannot wrap at the top of the range
    assign cnt_next_ext = {1'b0, run_cnt} + CW1'(1);
    assign limit_hit    = (limit_q != '0) && (cnt_next_ext >= {1'b0, limit_q});

    // Holds the software-programmed limit
    always_ff @(posedge clk) begin
        if (!rst_n)      limit_q <= CNT_W'(RST_LIMIT);
        else if (cfg_we) limit_q <= cfg_limit;
    end

    // Counts active cycles, clears on a switch, freezes on a pending timeout
    always_ff @(posedge clk) begin
        if (!rst_n)                               run_cnt <= '0;
        else if (sw_take)                         run_cnt <= '0;
        else if (!limit_hit && (run_cnt != '1))   run_cnt <= run_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/tsc_pc_bank.sv
// Per-thread program counter storage. One register per thread, built by a
// generate loop. A save from the switch logic wins over a pipeline update
// for the same thread in the same cycle. Assumes reset_vec is stable while
// reset is asserted.
module tsc_pc_bank
    import tsc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PC_W-1:0]               reset_vec,
    input  logic [NUM_THR-1:0]            upd_en,
    input  logic [NUM_THR-1:0][PC_W-1:0]  upd_pc,
    input  logic                          save_en,
    input  logic [TID_W-1:0]              save_tid,
    input  logic [PC_W-1:0]               save_pc,
    input  logic [TID_W-1:0]              rd_tid,
    output logic [PC_W-1:0]               rd_pc
);
    logic [NUM_THR-1:0][PC_W-1:0] pc_q;

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        // Thread g's PC: reset vector, switch save, or pipeline update
        always_ff @(posedge clk) begin
            if (!rst_n)
                pc_q[g] <= reset_vec;
            else if (save_en && (save_tid == TID_W'(g)))
                pc_q[g] <= save_pc;
            else if (upd_en[g])
                pc_q[g] <= upd_pc[g];
        end
    end

    // Read port for the fetch stage
    assign rd_pc = pc_q[rd_tid];
endmodule

// File: rtl/tsc_switch_fsm.sv
// Switch decision and active-thread state. A switch is wanted on a long
// stall event or on a pending timeout. It is taken only when the other
// thread is ready. A miss takes priority over the timeout as the recorded
// cause. Assumes long_evt refers to the currently active thread.
module tsc_switch_fsm
    import tsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               long_evt,
    input  logic               limit_hit,
    input  logic [NUM_THR-1:0] thr_ready,
    output logic               take,
    output logic [TID_W-1:0]   tid_q,
    output logic               flush_q,
    output sw_cause_e          cause_q
);
    logic [TID_W-1:0] other_tid;

    assign other_tid = ~tid_q;
    assign take      = (long_evt || limit_hit) && thr_ready[other_tid];

    // Active thread, one-cycle flush pulse and recorded cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tid_q   <= '0;
            flush_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            flush_q <= take;
            if (take) begin
                tid_q   <= other_tid;
                cause_q <= long_evt ? CAUSE_MISS : CAUSE_LIMIT;
            end
        end
    end
endmodule

// File: rtl/thread_switch_ctrl.sv
// Top of the two-thread switch-on-event controller. Decodes the stall
// code, wires the run timer, the switch decision and the PC bank together,
// and presents the active thread, its PC, its register bank and the flush
// request. Assumes restart_pc is valid whenever a long event is reported.
module thread_switch_ctrl
    import tsc_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int CNT_W     = 16,
    parameter int RST_LIMIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  reset_vec,
    input  logic [1:0]       stall_evt,
    input  logic [PC_W-1:0]  restart_pc,
    input  logic [1:0]       thr_ready,
    input  logic [1:0]       pc_upd_en,
    input  logic [PC_W-1:0]  pc_upd_t0,
    input  logic [PC_W-1:0]  pc_upd_t1,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_limit,
    output logic             active_tid,
    output logic             rf_bank_sel,
    output logic [PC_W-1:0]  active_pc,
    output logic             flush_req,
    output logic [1:0]       switch_cause
);
    logic                          long_evt;
    logic                          limit_hit;
    logic                          take;
    logic [CNT_W-1:0]              run_cnt;
    logic [CNT_W-1:0]              limit_q;
    logic [TID_W-1:0]              tid_q;
    sw_cause_e                     cause_q;
    logic [NUM_THR-1:0][PC_W-1:0]  upd_arr;

    // Only miss codes count as long-latency events
    assign long_evt = (stall_evt == EVT_DMISS) || (stall_evt == EVT_TMISS);

    // Pack the per-thread update values for the bank
    assign upd_arr[0] = pc_upd_t0;
    assign upd_arr[1] = pc_upd_t1;

    tsc_run_timer #(.CNT_W(CNT_W), .RST_LIMIT(RST_LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_limit (cfg_limit),
        .sw_take   (take),
        .limit_hit (limit_hit),
        .run_cnt   (run_cnt),
        .limit_q   (limit_q)
    );

    tsc_switch_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .long_evt  (long_evt),
        .limit_hit (limit_hit),
        .thr_ready (thr_ready),
        .take      (take),
        .tid_q     (tid_q),
        .flush_q   (flush_req),
        .cause_q   (cause_q)
    );

    tsc_pc_bank #(.PC_W(PC_W)) u_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_vec (reset_vec),
        .upd_en    (pc_upd_en),
        .upd_pc    (upd_arr),
        .save_en   (take && long_evt),
        .save_tid  (tid_q),
        .save_pc   (restart_pc),
        .rd_tid    (tid_q),
        .rd_pc     (active_pc)
    );

    assign active_tid   = tid_q;
    assign rf_bank_sel  = tid_q;
    assign switch_cause = cause_q;
endmodule

// File: rtl/tsc_chk.sv
// Property checker for thread_switch_ctrl, attached by bind. Observes the
// ports plus the timer's count, limit and flag.
module tsc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       stall_evt,
    input logic [1:0]       thr_ready,
    input logic             active_tid,
    input logic             flush_req,
    input logic [1:0]       switch_cause,
    input logic             limit_hit,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] limit_q
);
    logic long_seen;
    assign long_seen = stall_evt[1];

    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!flush_req && (switch_cause == 2'b00)));

    // R2
    flip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_tid != $past(active_tid)) |-> flush_req);

    // R2
    flush_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (active_tid != $past(active_tid)));

    // R5
    other_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (active_tid ? $past(thr_ready[1]) : $past(thr_ready[0])));

    // R4
    switch_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> ($past(long_seen) || $past(limit_hit)));

    // R9
    miss_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && $past(long_seen)) |-> (switch_cause == 2'b01));

    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (run_cnt == '0));

    // R7
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && ($past(limit_q) == '0)) |-> $past(long_seen));
endmodule

bind thread_switch_ctrl tsc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_evt    (stall_evt),
    .thr_ready    (thr_ready),
    .active_tid   (active_tid),
    .flush_req    (flush_req),
    .switch_cause (switch_cause),
    .limit_hit    (limit_hit),
    .run_cnt      (run_cnt),
    .limit_q      (limit_q)
);

// File: tb/test_thread_switch_ctrl.sv
// Self-checking bench: directed switch scenarios plus a sweep of run-length
// limits, with expected intervals and PCs computed here.
module test_thread_switch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [PC_W-1:0]  reset_vec;
    logic [1:0]       stall_evt;
    logic [PC_W-1:0]  restart_pc;
    logic [1:0]       thr_ready;
    logic [1:0]       pc_upd_en;
    logic [PC_W-1:0]  pc_upd_t0;
    logic [PC_W-1:0]  pc_upd_t1;
    logic             cfg_we;
    logic [CNT_W-1:0] cfg_limit;
    logic             active_tid;
    logic             rf_bank_sel;
    logic [PC_W-1:0]  active_pc;
    logic             flush_req;
    logic [1:0]       switch_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_switch_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) i_thread_switch_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reset_vec    (reset_vec),
        .stall_evt    (stall_evt),
        .restart_pc   (restart_pc),
        .thr_ready    (thr_ready),
        .pc_upd_en    (pc_upd_en),
        .pc_upd_t0    (pc_upd_t0),
        .pc_upd_t1    (pc_upd_t1),
        .cfg_we       (cfg_we),
        .cfg_limit    (cfg_limit),
        .active_tid   (active_tid),
        .rf_bank_sel  (rf_bank_sel),
        .active_pc    (active_pc),
        .flush_req    (flush_req),
        .switch_cause (switch_cause)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [PC_W-1:0] vec);
        rst_n     = 1'b0;
        reset_vec = vec;
        stall_evt = 2'b00;
        restart_pc = '0;
        thr_ready = 2'b11;
        pc_upd_en = 2'b00;
        pc_upd_t0 = '0;
        pc_upd_t1 = '0;
        cfg_we    = 1'b0;
        cfg_limit = '0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic set_limit(input int n);
        cfg_we    = 1'b1;
        cfg_limit = CNT_W'(n);
        tick();
        cfg_we    = 1'b0;
    endtask

    // Ticks until flush_req is seen; returns the number of ticks taken
    task automatic wait_flush(output int gap);
        gap = 0;
        do begin
            tick();
            gap++;
        end while (!flush_req && gap < 200);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int gap;
        int flushes;
        logic prev_tid;

        // ---- R1 reset state
        do_reset(32'h0000_1000);
        chk(active_tid == 1'b0, "R1 tid", active_tid, 0);
        chk(rf_bank_sel == 1'b0, "R1 bank", rf_bank_sel, 0);
        chk(active_pc == 32'h1000, "R1 pc", active_pc, 32'h1000);
        chk(flush_req == 1'b0, "R1 flush", flush_req, 0);
        chk(switch_cause == 2'b00, "R1 cause", switch_cause, 0);

        // ---- R4 none/short codes under every ready pattern
        for (int code = 0; code < 2; code++) begin
            for (int rdy = 0; rdy < 4; rdy++) begin
                stall_evt = 2'(code);
                thr_ready = 2'(rdy);
                tick();
                chk(active_tid == 1'b0 && !flush_req, "R4 no switch", active_tid, 0);
            end
        end
        stall_evt = 2'b00;
        thr_ready = 2'b11;

        // ---- R10 per-thread PC updates
        pc_upd_en = 2'b01; pc_upd_t0 = 32'h1100;
        tick();
        chk(active_pc == 32'h1100, "R10 active update", active_pc, 32'h1100);
        pc_upd_en = 2'b10; pc_upd_t1 = 32'h2200;
        tick();
        pc_upd_en = 2'b00;
        chk(active_pc == 32'h1100, "R10 inactive update", active_pc, 32'h1100);

        // ---- R5 miss with other thread not ready
        thr_ready = 2'b01;
        for (int code = 2; code < 4; code++) begin
            stall_evt = 2'(code);
            tick();
            chk(active_tid == 1'b0 && !flush_req, "R5 blocked miss", active_tid, 0);
        end

        // ---- R2 switch on translation miss
        thr_ready  = 2'b11;
        stall_evt  = 2'b11;
        restart_pc = 32'h1104;
        tick();
        stall_evt = 2'b00;
        chk(active_tid == 1'b1, "R2 tid", active_tid, 1);
        chk(rf_bank_sel == 1'b1, "R2 bank", rf_bank_sel, 1);
        chk(flush_req == 1'b1, "R2 flush", flush_req, 1);
        chk(active_pc == 32'h2200, "R2 new pc", active_pc, 32'h2200);
        chk(switch_cause == 2'b01, "R2 cause", switch_cause, 1);
        tick();
        chk(flush_req == 1'b0, "R2 one-cycle flush", flush_req, 0);
        chk(active_tid == 1'b1, "R2 stays", active_tid, 1);

        // ---- R3 switch back on data miss, restart address kept
        stall_evt  = 2'b10;
        restart_pc = 32'h2208;
        tick();
        stall_evt = 2'b00;
        chk(active_tid == 1'b0, "R3 tid", active_tid, 0);
        chk(active_pc == 32'h1104, "R3 restart pc", active_pc, 32'h1104);
        stall_evt = 2'b10;
        restart_pc = 32'h110C;
        tick();
        stall_evt = 2'b00;
        chk(active_pc == 32'h2208, "R3 restart pc t1", active_pc, 32'h2208);

        // ---- R7 zero limit never forces a switch
        flushes = 0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (flush_req) flushes++;
        end
        chk(flushes == 0, "R7 no timeout", flushes, 0);

        // ---- R6/R8/R11 sweep of limits
        for (int n = 1; n <= 8; n++) begin
            do_reset(32'h0000_4000);
            set_limit(n);
            wait_flush(gap);
            for (int k = 0; k < 3; k++) begin
                prev_tid = active_tid;
                wait_flush(gap);
                chk(gap == n, "R6 R8 R11 interval", gap, n);
                chk(switch_cause == 2'b10, "R6 cause", switch_cause, 2);
                chk(active_tid != prev_tid, "R6 alternate", active_tid, !prev_tid);
            end
        end

        // ---- R6 pending timeout waits for readiness
        do_reset(32'h0000_5000);
        thr_ready = 2'b01;
        set_limit(3);
        flushes = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (flush_req) flushes++;
        end
        chk(flushes == 0 && active_tid == 1'b0, "R6 held", flushes, 0);
        thr_ready = 2'b11;
        tick();
        chk(flush_req == 1'b1 && active_tid == 1'b1, "R6 late switch", active_tid, 1);
        chk(switch_cause == 2'b10, "R6 late cause", switch_cause, 2);

        // ---- R9 miss and timeout in the same cycle
        do_reset(32'h0000_6000);
        set_limit(4);
        wait_flush(gap);
        tick(); tick(); tick();
        prev_tid   = active_tid;
        stall_evt  = 2'b10;
        restart_pc = 32'h0000_603C;
        tick();
        stall_evt = 2'b00;
        chk(flush_req == 1'b1 && active_tid != prev_tid, "R9 single switch", active_tid, !prev_tid);
        chk(switch_cause == 2'b01, "R9 miss cause", switch_cause, 1);
        wait_flush(gap);
        chk(gap == 4, "R9 R8 full run after", gap, 4);
        chk(active_pc == 32'h0000_603C, "R9 R3 saved pc", active_pc, 32'h603C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule